// File: doc/BRIEF.md
# Serial Transmitter with Bit-Aligned Line Break

This block is the send half of an asynchronous serial port. Software pushes bytes into a 16-entry queue. The block turns each byte into a frame on a single output line: a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. An external baud strobe paces the frames, and every bit lasts sixteen strobes. Framing, parity sense and a test mode that sends deliberately wrong parity come from a set of level inputs. These inputs are captured when each frame begins.

A break request holds the line low. The low level starts only where a bit period ends. When the break starts, the byte in flight is abandoned and the queue is emptied in the same cycle. Bytes written after that point are kept. They go out once the request is withdrawn. The line returns high on the first baud strobe after the request drops. A queue-empty flag tells software when it may refill the queue. A sticky flag records writes that were lost to a full queue.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset the line `txd` is high, `thre` is high and `ovf` is low.
- R2: A frame is one low start bit followed by N data bits, least significant bit first, where N = 5 + `fmt_sel[1:0]`. Every bit lasts exactly 16 `baud_tick` strobes.
- R3: `fmt_sel[2]` = 0 sends one high stop bit and `fmt_sel[2]` = 1 sends two.
- R4: With `par_on` = 0 the stop bits follow the data directly. With `par_on` = 1 a parity bit sits between the data and the stop bits.
- R5: With `par_even` = 0 the data bits plus the parity bit hold an odd count of ones. With `par_even` = 1 they hold an even count.
- R6: With `par_on` = 1 and `par_flip` = 1 the parity bit is inverted. With `par_on` = 0, `par_flip` has no effect on the frame.
- R7: The queue holds 16 bytes and sends them in write order. `thre` is high exactly when the queue holds no byte.
- R8: A write while the queue holds 16 bytes is dropped and sets `ovf`. `ovf` stays set until a cycle with `ovf_clr` high.
- R9: After `brk_req` rises, `txd` keeps its value until the current 16-strobe bit period ends. It then stays low for as long as `brk_req` is high.
- R10: On break entry the queue is emptied and the byte being sent is discarded. Neither that byte nor any emptied byte is ever sent.
- R11: Bytes written while the break is active are kept and sent, in order, after the break ends.
- R12: With the break active, the first `baud_tick` after `brk_req` falls drives `txd` high. Normal framing then resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick | input | 1 | One-cycle baud strobe, 16 per bit |
| wr_en | input | 1 | Write strobe into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| fmt_sel | input | 3 | [1:0] data length code (5..8 bits), [2] two stop bits |
| par_on | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| par_flip | input | 1 | Send inverted parity (test mode) |
| brk_req | input | 1 | Hold the line low from the next bit boundary |
| ovf_clr | input | 1 | Clears the overflow flag |
| txd | output | 1 | Serial output, idle high |
| thre | output | 1 | Transmit queue empty |
| ovf | output | 1 | Sticky queue overflow flag |

## Verification
The properties assume that `baud_tick` is a strobe sampled once per clock. They also assume that `rst_n` reaches the logic through the internal two-stage release, so their past-value references start from a known idle line. The bench changes the framing and parity inputs only while the line is idle and the queue is empty. Every frame therefore uses the settings under which its bytes were written. The bench writes during a break only after the flush has visibly happened, and it never writes in the same cycle as a break entry. The baud strobe is random but its gaps stay short, so every frame finishes well inside the run.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       two_stop;
    logic       par_on;
    logic       par_even;
    logic       par_flip;
  } line_cfg_t;

endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW-1:0]   wptr_inc, rptr_inc;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            push, pop;

  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign push  = wr && !full && !flush;
  assign pop   = rd && !empty && !flush;

  // pointer wrap: free wrap for power-of-two depth, explicit compare otherwise
  generate
    if (DEPTH == (1 << AW)) begin : g_pow2
      assign wptr_inc = wptr_q + 1'b1;
      assign rptr_inc = rptr_q + 1'b1;
    end else begin : g_wrap
      assign wptr_inc = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      assign rptr_inc = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = wptr_inc;
      if (pop)  rptr_d = rptr_inc;
      cnt_d = cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R8
  keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && full && !rd && !flush |=> full);

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              brk_req,
  input  line_cfg_t         cfg,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              fifo_flush,
  output logic              in_brk,
  output logic              txd
);

  localparam int CW      = $clog2(OVS);
  localparam int BW      = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;

  tx_state_e          state_q, state_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [DATA_W-1:0]  sh_q, sh_d;
  logic [BW-1:0]      bits_q, bits_d;
  line_cfg_t          cfg_q, cfg_d;
  logic               acc_q, acc_d;
  logic               bound, start_new;

  assign bound = tick && (cnt_q == CW'(OVS - 1));

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    bits_d     = bits_q;
    cfg_d      = cfg_q;
    acc_d      = acc_q;
    fifo_pop   = 1'b0;
    fifo_flush = 1'b0;
    start_new  = 1'b0;

    if (tick) cnt_d = bound ? '0 : cnt_q + 1'b1;

    if (state_q != ST_BRK && bound && brk_req) begin
      state_d    = ST_BRK;
      fifo_flush = 1'b1;
    end else if (state_q == ST_BRK) begin
      if (tick && !brk_req) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    end else if (bound) begin
      case (state_q)
        ST_IDLE:  start_new = !fifo_empty;
        ST_START: begin
          state_d = ST_DATA;
          bits_d  = BW'(MIN_LEN - 1) + BW'(cfg_q.len_sel);
        end
        ST_DATA: begin
          acc_d = acc_q ^ sh_q[0];
          sh_d  = sh_q >> 1;
          if (bits_q == '0) begin
            state_d = cfg_q.par_on ? ST_PAR : ST_STOP;
            bits_d  = BW'(cfg_q.two_stop);
          end else begin
            bits_d = bits_q - 1'b1;
          end
        end
        ST_PAR: begin
          state_d = ST_STOP;
          bits_d  = BW'(cfg_q.two_stop);
        end
        ST_STOP: begin
          if (bits_q == '0) begin
            if (!fifo_empty) start_new = 1'b1;
            else             state_d   = ST_IDLE;
          end else begin
            bits_d = bits_q - 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (start_new) begin
      state_d  = ST_START;
      fifo_pop = 1'b1;
      sh_d     = fifo_data;
      cfg_d    = cfg;
      acc_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      bits_q  <= '0;
      cfg_q   <= '0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      bits_q  <= bits_d;
      cfg_q   <= cfg_d;
      acc_q   <= acc_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START, ST_BRK: txd = 1'b0;
      ST_DATA:          txd = sh_q[0];
      ST_PAR:           txd = acc_q ^ ~cfg_q.par_even ^ cfg_q.par_flip;
      default:          txd = 1'b1;
    endcase
  end

  assign in_brk = (state_q == ST_BRK);

  // R9
  brk_on_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_brk) |-> $past(bound));

  // R12
  brk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_brk && tick && !brk_req |=> !in_brk && txd);

  // R2
  txd_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) && !$past(in_brk) |-> $past(bound));

endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        fmt_sel,
  input  logic              par_on,
  input  logic              par_even,
  input  logic              par_flip,
  input  logic              brk_req,
  input  logic              ovf_clr,
  output logic              txd,
  output logic              thre,
  output logic              ovf
);

  logic              rst_meta, rst_q;
  line_cfg_t         cfg;
  logic              q_empty, q_full, q_pop, q_flush, in_brk;
  logic [DATA_W-1:0] q_data;
  logic              ovf_q, ovf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  always_comb begin
    cfg.len_sel  = fmt_sel[1:0];
    cfg.two_stop = fmt_sel[2];
    cfg.par_on   = par_on;
    cfg.par_even = par_even;
    cfg.par_flip = par_flip;
  end

  tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_q),
    .flush (q_flush),
    .wr    (wr_en),
    .wdata (wr_data),
    .rd    (q_pop),
    .rdata (q_data),
    .empty (q_empty),
    .full  (q_full)
  );

  tx_serializer #(.DATA_W(DATA_W), .OVS(OVS)) i_ser (
    .clk        (clk),
    .rst_n      (rst_q),
    .tick       (baud_tick),
    .brk_req    (brk_req),
    .cfg        (cfg),
    .fifo_empty (q_empty),
    .fifo_data  (q_data),
    .fifo_pop   (q_pop),
    .fifo_flush (q_flush),
    .in_brk     (in_brk),
    .txd        (txd)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_clr)         ovf_d = 1'b0;
    if (wr_en && q_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf  = ovf_q;
  assign thre = q_empty;

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wr_en && q_full && !ovf_clr |=> ovf);

  // R10
  brk_flush_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(in_brk) |-> thre);

endmodule

// File: tb/test_uart_tx_brk.sv
`timescale 1ns/1ps
module test_uart_tx_brk;

  logic       clk = 1'b0;
  logic       rst_n, baud_tick, wr_en, par_on, par_even, par_flip, brk_req, ovf_clr;
  logic [7:0] wr_data;
  logic [2:0] fmt_sel;
  logic       txd, thre, ovf;

  always #2 clk = ~clk;

  uart_tx_brk i_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .fmt_sel(fmt_sel), .par_on(par_on), .par_even(par_even), .par_flip(par_flip),
    .brk_req(brk_req), .ovf_clr(ovf_clr), .txd(txd), .thre(thre), .ovf(ovf)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int tick_total = 0;
  bit mon_en = 0;
  bit tick_q = 0;

  // expected frames
  logic [7:0] ex_d [0:511];
  int ex_len [0:511], ex_two [0:511], ex_pe [0:511], ex_pev [0:511], ex_pf [0:511];
  int ex_wr = 0, rx_i = 0;
  int c_len = 3, c_two = 0, c_pe = 0, c_pev = 0, c_pf = 0;

  // decoder
  int dstate = 0, t = 0, nbits = 10;
  bit rb [0:15];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic eval_frame();
    int i, nd, ones, p;
    logic [7:0] dat, ex, mask;
    i = rx_i;
    rx_i++;
    if (i >= ex_wr) return;
    nd   = 5 + ex_len[i];
    mask = 8'((16'h1 << nd) - 1);
    dat  = '0;
    for (int j = 0; j < nd; j++) dat[j] = rb[1 + j];
    ex = ex_d[i] & mask;
    chk(rb[0] == 1'b0, "R2", "start bit", rb[0], 0);
    chk(dat == ex, "R2", "data bits", dat, ex);
    if (ex_pe[i] != 0) begin
      ones = $countones(ex);
      p = (ex_pev[i] != 0) ? (ones % 2) : (1 - (ones % 2));
      if (ex_pf[i] != 0) begin
        p = 1 - p;
        chk(rb[1 + nd] == p[0], "R6", "forced parity", rb[1 + nd], p);
      end else begin
        chk(rb[1 + nd] == p[0], "R5", "parity bit", rb[1 + nd], p);
      end
    end
    chk(rb[1 + nd + ex_pe[i]] == 1'b1, "R4", "first stop after data/parity",
        rb[1 + nd + ex_pe[i]], 1);
    if (ex_two[i] != 0)
      chk(rb[nbits - 1] == 1'b1, "R3", "second stop bit", rb[nbits - 1], 1);
  endtask

  task automatic decode();
    if (dstate == 0) begin
      if (txd == 1'b0) begin
        dstate = 1;
        t = 0;
        if (rx_i >= ex_wr) begin
          chk(0, "R10", "unexpected frame", rx_i, ex_wr);
          nbits = 10;
        end else begin
          nbits = 1 + 5 + ex_len[rx_i] + ex_pe[rx_i] + 1 + ex_two[rx_i];
        end
      end
    end else begin
      t++;
      if (t % 16 == 8) begin
        rb[t / 16] = txd;
        if (t / 16 == nbits - 1) begin
          eval_frame();
          dstate = 0;
        end
      end
    end
  endtask

  // baud strobe generator and line monitor
  initial begin
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (tick_q) begin
        tick_total++;
        if (mon_en) decode();
      end
      if (!mon_en) dstate = 0;
      tick_q    = ($urandom_range(0, 2) != 0);
      baud_tick = tick_q;
    end
  end

  task automatic wait_ticks(input int n);
    int s;
    s = tick_total;
    while (tick_total < s + n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_cfg(input int l, input int two, input int pe, input int pev, input int pf);
    c_len = l; c_two = two; c_pe = pe; c_pev = pev; c_pf = pf;
    fmt_sel  = {two[0], l[1:0]};
    par_on   = pe[0];
    par_even = pev[0];
    par_flip = pf[0];
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit rec);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    if (rec) begin
      ex_d[ex_wr] = d; ex_len[ex_wr] = c_len; ex_two[ex_wr] = c_two;
      ex_pe[ex_wr] = c_pe; ex_pev[ex_wr] = c_pev; ex_pf[ex_wr] = c_pf;
      ex_wr++;
    end
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (rx_i < ex_wr || dstate != 0) begin
      @(negedge clk); #1;
    end
    wait_ticks(40);
    chk(thre == 1'b1, "R7", "thre high once queue sent", thre, 1);
    chk(rx_i == ex_wr, "R7", "frame count", rx_i, ex_wr);
  endtask

  task automatic batch(input int n);
    for (int k = 0; k < n; k++) begin
      wr_byte(8'($urandom_range(0, 255)), 1);
      cycles($urandom_range(0, 30));
    end
    drain();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", rx_i, ex_wr);
    summary();
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; brk_req = 1'b0; ovf_clr = 1'b0;
    set_cfg(3, 0, 0, 0, 0);
    cycles(6);
    rst_n = 1'b1;
    cycles(4);
    // R1
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(thre == 1'b1, "R1", "thre after reset", thre, 1);
    chk(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);
    mon_en = 1;

    // directed framing corners
    set_cfg(3, 0, 0, 0, 0); wr_byte(8'h00, 1); wr_byte(8'hFF, 1); wr_byte(8'h81, 1); drain();
    set_cfg(3, 0, 1, 0, 0); batch(3);   // R5 odd
    set_cfg(0, 1, 1, 1, 0); batch(3);   // R5 even, R3 two stops
    set_cfg(3, 0, 1, 1, 1); batch(3);   // R6 forced
    set_cfg(2, 0, 0, 0, 1); batch(3);   // R6 no effect without parity
    set_cfg(1, 1, 0, 0, 0); batch(2);

    // random formats
    for (int b = 0; b < 14; b++) begin
      set_cfg($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 1), $urandom_range(0, 1));
      batch($urandom_range(1, 5));
    end

    // break in the middle of a frame
    set_cfg(3, 0, 0, 0, 0);
    wr_byte(8'hA5, 1); wr_byte(8'h3C, 1); wr_byte(8'h0F, 1);
    while (dstate == 0) begin @(negedge clk); #1; end
    brk_req = 1'b1; mon_en = 0;
    ex_wr = rx_i;
    chk(thre == 1'b0, "R10", "queue kept until bit boundary", thre, 0);
    wait_ticks(17);
    chk(thre == 1'b1, "R10", "queue flushed at break entry", thre, 1);
    chk(txd == 1'b0, "R9", "line low in break", txd, 0);
    begin
      int lowbad = 0;
      for (int k = 0; k < 40; k++) begin
        wait_ticks(1);
        if (txd !== 1'b0) lowbad++;
      end
      chk(lowbad == 0, "R9", "continuous low during break", lowbad, 0);
    end
    wr_byte(8'h5A, 1); wr_byte(8'hC3, 1);
    chk(thre == 1'b0, "R11", "writes during break kept", thre, 0);
    wait_ticks(3);
    chk(txd == 1'b0, "R11", "no send while break held", txd, 0);
    brk_req = 1'b0;
    chk(txd == 1'b0, "R12", "still low before next strobe", txd, 0);
    wait_ticks(1);
    chk(txd == 1'b1, "R12", "high on first strobe after release", txd, 1);
    mon_en = 1;
    drain();
    chk(rx_i == ex_wr, "R11", "post-break bytes sent, aborted ones not", rx_i, ex_wr);

    // break entry waits for the bit boundary
    brk_req = 1'b1; mon_en = 0;
    wait_ticks(20);
    brk_req = 1'b0;
    wait_ticks(1);
    chk(txd == 1'b1, "R12", "recovered from idle break", txd, 1);
    wait_ticks(5);
    brk_req = 1'b1;
    wait_ticks(10);
    chk(txd == 1'b1, "R9", "no break before boundary (15 strobes)", txd, 1);
    wait_ticks(1);
    chk(txd == 1'b0, "R9", "break at boundary (16 strobes)", txd, 0);

    // fill the queue during break
    set_cfg(3, 0, 1, 0, 0);
    for (int k = 0; k < 16; k++) wr_byte(8'(k * 17 + 3), 1);
    chk(thre == 1'b0, "R7", "queue holds bytes", thre, 0);
    chk(ovf == 1'b0, "R8", "no overflow at 16", ovf, 0);
    wr_byte(8'hEE, 0);
    chk(ovf == 1'b1, "R8", "overflow on 17th write", ovf, 1);
    cycles(5);
    chk(ovf == 1'b1, "R8", "overflow sticky", ovf, 1);
    ovf_clr = 1'b1; cycles(1); ovf_clr = 1'b0; cycles(1);
    chk(ovf == 1'b0, "R8", "overflow cleared", ovf, 0);
    brk_req = 1'b0;
    wait_ticks(1);
    chk(txd == 1'b1, "R12", "recovered before queued frames", txd, 1);
    mon_en = 1;
    drain();
    chk(rx_i == ex_wr, "R7", "all 16 queued bytes sent in order, dropped one absent", rx_i, ex_wr);

    summary();
  end

endmodule